// File: doc/BRIEF.md
# Activity-Based Clock Gating Controller

The controller watches an outstanding-transaction count and stops a downstream clock when the count has been zero long enough, then restarts it when work returns. It waits before gating and again before ungating. Each wait is a parameter from 0 to 10 cycles. Requests are cancelled if the count changes direction during a wait. The state code is a fixed, visible output so that neighbouring checks can key on it.

The enable is held in a latch that is transparent while the source clock is low, and the latch output is ANDed with the clock. The gated clock therefore only ever starts or stops on a whole high phase. Reset puts the block in idle with the clock running.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While rst_ni is low, state_o is 0, gate_en_o is 1 and gclk_o follows clk_i.
- R2: state_o uses 0 for idle, 1 for waiting to gate and 2 for gated, and never shows 3. An illegal code returns to 0 on the next rising edge.
- R3: From idle, let the count be sampled zero on rising edge k and on every edge through k+GATE_DLY. state_o becomes 2 after edge k+GATE_DLY and shows 1 during the wait. With GATE_DLY of 0, it goes straight from 0 to 2 at edge k.
- R4: A nonzero count sampled while state_o is 1 returns state_o to 0 at that edge, cancelling the pending gate.
- R5: While state_o is 2, each edge that samples a zero count leaves state_o at 2.
- R6: From the gated state, let the count be sampled nonzero on edges j through j+UNGATE_DLY. state_o becomes 0 after edge j+UNGATE_DLY and stays 2 before that.
- R7: A zero count sampled during the ungate wait keeps state_o at 2 and restarts the ungate wait from the next nonzero sample.
- R8: gate_en_o is 1 exactly when state_o is not 2. A high phase of clk_i appears on gclk_o only if state_o was not 2 during the low phase before it.
- R9: Delay parameters above 10 are clamped to 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| txn_cnt_i | input | CNT_W | Outstanding-transaction count |
| gclk_o | output | 1 | Glitch-free gated clock |
| gate_en_o | output | 1 | Clock enable, 1 = clock runs |
| state_o | output | 2 | State code: 0 idle, 1 waiting, 2 gated |

## Verification
On every falling edge, the assertions check the legal state codes and that the gated state holds while the count stays zero. Run counters check both timing windows. Gating must not happen before GATE_DLY+1 zero samples and must have happened once that many have been seen. Ungating follows the same rule with nonzero samples. Cancelled requests, restarted ungate waits, the clamp of an oversized delay and the exact clock phases removed from gclk_o are shown only by the bench scenarios, which run two instances at opposite delay extremes.

// File: rtl/clk_gate_pkg.sv
`timescale 1ns/1ps
package clk_gate_pkg;
  localparam int unsigned MAX_DLY = 10;
  localparam int unsigned DLY_W   = $clog2(MAX_DLY + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GATED = 2'd2
  } gc_state_e;
endpackage

// File: rtl/gc_dly_cnt.sv
`timescale 1ns/1ps
module gc_dly_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (load_i)             cnt_q <= val_i;
    else if (dec_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R3
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i) |-> !zero_o);
endmodule

// File: rtl/gc_clk_gate.sv
`timescale 1ns/1ps
module gc_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  logic en_l;

  // transparent while clock low: enable only changes outside high phase
  always_latch begin
    if (!clk_i) en_l = en_i;
  end

  assign gclk_o = clk_i & en_l;
endmodule

// File: rtl/clk_gate_ctrl.sv
`timescale 1ns/1ps
module clk_gate_ctrl
  import clk_gate_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned GATE_DLY   = 4,
  parameter int unsigned UNGATE_DLY = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] txn_cnt_i,
  output logic             gclk_o,
  output logic             gate_en_o,
  output logic [1:0]       state_o
);
  localparam int unsigned G_DLY  = (GATE_DLY   > MAX_DLY) ? MAX_DLY : GATE_DLY;
  localparam int unsigned U_DLY  = (UNGATE_DLY > MAX_DLY) ? MAX_DLY : UNGATE_DLY;
  localparam logic [DLY_W-1:0] G_LD = (G_DLY > 0) ? DLY_W'(G_DLY - 1) : '0;
  localparam logic [DLY_W-1:0] U_LD = (U_DLY > 0) ? DLY_W'(U_DLY - 1) : '0;
  localparam int unsigned RUN_W  = DLY_W + 1;

  gc_state_e        state_q, state_d;
  logic             pend_q, pend_d;
  logic             ld, dec, tmr_zero;
  logic [DLY_W-1:0] ld_val;
  logic             cnt_zero;

  assign cnt_zero = (txn_cnt_i == '0);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    ld      = 1'b0;
    ld_val  = '0;
    dec     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cnt_zero) begin
          if (G_DLY == 0) state_d = ST_GATED;
          else begin
            state_d = ST_WAIT;
            ld      = 1'b1;
            ld_val  = G_LD;
          end
        end
      end
      ST_WAIT: begin
        if (!cnt_zero)     state_d = ST_IDLE;
        else if (tmr_zero) state_d = ST_GATED;
        else               dec     = 1'b1;
      end
      ST_GATED: begin
        if (!pend_q) begin
          if (!cnt_zero) begin
            if (U_DLY == 0) state_d = ST_IDLE;
            else begin
              pend_d = 1'b1;
              ld     = 1'b1;
              ld_val = U_LD;
            end
          end
        end else if (cnt_zero) begin
          pend_d = 1'b0;
        end else if (tmr_zero) begin
          state_d = ST_IDLE;
          pend_d  = 1'b0;
        end else begin
          dec = 1'b1;
        end
      end
      default: begin
        state_d = ST_IDLE;
        pend_d  = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
    end
  end

  gc_dly_cnt #(.W(DLY_W)) i_dly_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (ld),
    .val_i  (ld_val),
    .dec_i  (dec),
    .zero_o (tmr_zero)
  );

  assign gate_en_o = (state_q != ST_GATED);
  assign state_o   = state_q;

  gc_clk_gate i_clk_gate (
    .clk_i  (clk_i),
    .en_i   (gate_en_o),
    .gclk_o (gclk_o)
  );

  // run counters of consecutive zero / nonzero samples, checked at falling edge
  logic [RUN_W-1:0] zero_run, nz_run;
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zero_run <= '0;
      nz_run   <= '0;
    end else if (cnt_zero) begin
      nz_run   <= '0;
      zero_run <= (&zero_run) ? zero_run : zero_run + 1'b1;
    end else begin
      zero_run <= '0;
      nz_run   <= (&nz_run) ? nz_run : nz_run + 1'b1;
    end
  end

  // R2
  state_legal_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    state_o != 2'd3);

  // R5
  gated_hold_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    ($past(state_o) == 2'd2 && $past(txn_cnt_i) == '0) |-> state_o == 2'd2);

  // R3
  gate_min_dly_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(state_o == 2'd2) |-> zero_run >= RUN_W'(G_DLY + 1));

  // R3
  gate_max_dly_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (zero_run >= RUN_W'(G_DLY + 1)) |-> state_o == 2'd2);

  // R6
  ungate_min_dly_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(state_o == 2'd2) |-> nz_run >= RUN_W'(U_DLY + 1));

  // R6
  ungate_max_dly_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (nz_run >= RUN_W'(U_DLY + 1)) |-> state_o == 2'd0);
endmodule

// File: tb/test_clk_gate_ctrl.sv
`timescale 1ns/1ps
module test_clk_gate_ctrl;
  localparam int CW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] txn = '0;
  logic [1:0]    gclk, gen;
  logic [1:0]    st_a, st_b;

  always #5 clk = ~clk;

  clk_gate_ctrl #(.CNT_W(CW), .GATE_DLY(4), .UNGATE_DLY(2)) i_clk_gate_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .txn_cnt_i(txn),
    .gclk_o(gclk[0]), .gate_en_o(gen[0]), .state_o(st_a));

  // R9: oversized ungate delay, zero gate delay
  clk_gate_ctrl #(.CNT_W(CW), .GATE_DLY(0), .UNGATE_DLY(13)) i_clk_gate_ctrl_b (
    .clk_i(clk), .rst_ni(rst_n), .txn_cnt_i(txn),
    .gclk_o(gclk[1]), .gate_en_o(gen[1]), .state_o(st_b));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int dly[2]  = '{4, 0};
  int udly[2] = '{2, 10};
  int ms[2], mp[2], mt[2];

  task automatic chk(input string tag, input int act, input int exp, input int k);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s dut%0d t=%0t act=%0d exp=%0d", tag, k, $time, act, exp);
    end
  endtask

  function automatic void step(input int k, input bit nz);
    case (ms[k])
      0: if (!nz) begin
           if (dly[k] == 0) ms[k] = 2;
           else begin ms[k] = 1; mt[k] = dly[k] - 1; end
         end
      1: if (nz) ms[k] = 0;
         else if (mt[k] == 0) ms[k] = 2;
         else mt[k]--;
      default: begin
        if (mp[k] == 0) begin
          if (nz) begin
            if (udly[k] == 0) ms[k] = 0;
            else begin mp[k] = 1; mt[k] = udly[k] - 1; end
          end
        end else if (!nz) mp[k] = 0;
        else if (mt[k] == 0) begin ms[k] = 0; mp[k] = 0; end
        else mt[k]--;
      end
    endcase
  endfunction

  function automatic string pick_tag(input int k, input int old, input int oldp, input bit nz);
    if (old == 1 && nz)       return "R4";
    if (old != 2)             return "R3";
    if (!nz)                  return (oldp != 0) ? "R7" : "R5";
    return (k == 1) ? "R9" : "R6";
  endfunction

  // called at posedge+4; drives value, samples at posedge+2 of next edge
  task automatic cycle(input logic [CW-1:0] v);
    int    old[2];
    int    oldp[2];
    string tg[2];
    txn = v;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      old[k]  = ms[k];
      oldp[k] = mp[k];
      tg[k]   = pick_tag(k, old[k], oldp[k], v != 0);
      step(k, v != 0);
    end
    #2;
    chk(tg[0], st_a, ms[0], 0);
    chk(tg[1], st_b, ms[1], 1);
    for (int k = 0; k < 2; k++) begin
      chk("R8", gclk[k], (old[k] != 2) ? 1 : 0, k);
      chk("R8", gen[k], (ms[k] != 2) ? 1 : 0, k);
    end
    chk("R2", (st_a == 2'd3) ? 1 : 0, 0, 0);
    #2;
  endtask

  task automatic run(input logic [CW-1:0] v, input int n);
    for (int i = 0; i < n; i++) cycle(v);
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int k = 0; k < 2; k++) begin ms[k] = 0; mp[k] = 0; mt[k] = 0; end
    // R1: reset state
    repeat (3) begin
      @(posedge clk); #2;
      chk("R1", st_a, 0, 0);
      chk("R1", st_b, 0, 1);
      chk("R1", gen, 2'b11, 0);
      chk("R1", gclk, 2'b11, 0);
      #2;
    end
    rst_n = 1'b1;
    // directed corners
    run(8'd0, 8);             // R3 gate after delay, R5 hold
    cycle(8'd3); run(8'd0, 3); // R7 aborted ungate
    run(8'd5, 13);            // R6 ungate, R9 clamp on second instance
    run(8'd0, 2); cycle(8'd1); // R4 cancel pending gate
    run(8'd0, 20);
    run(8'd7, 4); cycle(8'd0); run(8'd9, 12); // R7 restart
    run(8'd0, 1); run(8'd2, 3);
    // random bursts
    for (int s = 0; s < 300; s++) begin
      bit z;
      int len;
      logic [CW-1:0] v;
      z   = $urandom_range(0, 1);
      len = $urandom_range(1, 14);
      v   = z ? '0 : CW'($urandom_range(1, 255));
      run(v, len);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule